// File: doc/BRIEF.md
# Smart card character transceiver

This block sends and receives single characters on a half-duplex smart card line. Each character occupies ten elementary time units (etu): a low start bit, eight data bits and one parity bit. An input strobe that pulses a fixed number of times per etu paces the block. The transmitter registers every slot boundary on that strobe. The receiver finds the falling start edge on the idle-high line and samples each bit near the middle of its etu.

Three control inputs select the bit convention. One chooses whether the most significant bit goes first. One inverts the line level of the eight data bits. One inverts the parity bit. Direct convention sets all three to 0. Inverse convention sets all three to 1, because the data inversion never reaches the parity bit. The block works only in block transfer mode. A parity error is flagged but is never signalled on the line, and no character is ever repeated. The transmit-end flag therefore follows a fixed schedule.

The line is open-drain. The block pulls it low for the low state, releases it for the high state, and leaves it released while idle. Bytes enter and leave through valid/ready pairs. Sticky parity-error and overrun flags stay set until a clear pulse.

Top module: `sc_char_xcvr`

## Requirements
- R1: After reset the line is released, `tx_ready` and `stat_tx_end` are 1, and `rx_valid`, `stat_parity_err`, `stat_overrun` and `stat_err_sig` are 0.
- R2: A byte accepted on `tx_valid && tx_ready` is sent as slots 0..9. Each slot lasts OS_RATE strobes, and slot k begins at strobe k*OS_RATE after acceptance. Slot 0 is low. With `cfg_msb_first`=0 and `cfg_invert`=0, slot k (1..8) carries data bit k-1, and a 1 is the released (high) level.
- R3: With `cfg_msb_first`=1, slot k (1..8) carries data bit 8-k. With `cfg_invert`=1, every data slot level is inverted. The slot 9 level is always the XOR of the eight data bits XOR `cfg_par_odd`, whatever `cfg_invert` says.
- R4: The line is released for at least 2 etu after slot 9. `tx_ready` stays 0 from acceptance until 12 etu (48 strobes at OS_RATE=4) have passed, and the line is never pulled low while `tx_ready` is 1.
- R5: `stat_tx_end` clears on acceptance and sets exactly 11.5 etu (46 strobes at OS_RATE=4) after it.
- R6: The receiver decodes a frame with the same convention rules as R2 and R3. A direct-convention initial character decodes to 0x3B, and an inverse-convention one decodes to 0x3F.
- R7: A received parity mismatch still delivers the byte and sets `stat_parity_err`. The flag holds until an `err_clr` pulse, and the block never pulls the line low in reply.
- R8: `stat_err_sig` reads 0 at all times, including after parity errors.
- R9: `rx_valid` and `rx_data` hold until `rx_ready`. A character that completes while `rx_valid` is 1 sets `stat_overrun` (sticky until `err_clr`) and leaves `rx_data` unchanged.
- R10: A low pulse shorter than half an etu is rejected as a false start and delivers nothing, and the next real frame is still received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling strobe, OS_RATE pulses per etu |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_invert | input | 1 | 1: invert data bit levels (not parity) |
| cfg_par_odd | input | 1 | 1: invert the parity bit level |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consume received byte |
| err_clr | input | 1 | Clears parity-error and overrun flags |
| stat_parity_err | output | 1 | Sticky received parity error |
| stat_overrun | output | 1 | Sticky receive overrun |
| stat_tx_end | output | 1 | Transmission end |
| stat_err_sig | output | 1 | Error-signal status, always 0 |
| line_in | input | 1 | Sensed line level |
| line_drive_low | output | 1 | 1 pulls the line low |

## Verification
The bench counts strobes from the acceptance edge. It samples the transmit slot k at strobe 4k+2, which is mid-slot, and reads every value one time step after the edge. It checks `stat_tx_end` at strobe 42, where it must still be 0, and at strobe 46, where it must be 1. It checks `tx_ready` at strobe 47, where it must be 0, and at strobe 48, where it must be 1. Receive results are read only after the parity slot has ended and two further etu of guard have passed. That leaves margin for the two-stage input synchroniser and for the up-to-one-strobe lag in start detection. False-start and no-error-signal checks are read at the ports before any later stimulus.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam int SLOTS_PER_CHAR = 10;
   localparam int DATA_W         = 8;

   // Line levels for slots 0..9 (bit i = slot i, 1 = released/high)
   function automatic logic [SLOTS_PER_CHAR-1:0] make_levels(
      input logic [DATA_W-1:0] d,
      input logic              msb_first,
      input logic              invert,
      input logic              par_odd
   );
      logic [SLOTS_PER_CHAR-1:0] lv;
      lv    = '0;
      lv[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         lv[i+1] = (msb_first ? d[DATA_W-1-i] : d[i]) ^ invert;
      end
      lv[SLOTS_PER_CHAR-1] = (^d) ^ par_odd;
      return lv;
   endfunction

   function automatic logic parity_fail(
      input logic [DATA_W-1:0] d,
      input logic              par_lvl,
      input logic              par_odd
   );
      return ((^d) ^ par_lvl) != par_odd;
   endfunction

endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q_out = d_in;
      end else if (STAGES == 1) begin : g_one
         logic r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= 1'b1;
            else        r_q <= d_in;
         end
         assign q_out = r_q;
      end else begin : g_chain
         logic [STAGES-1:0] r_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '1;
            else        r_q <= {r_q[STAGES-2:0], d_in};
         end
         assign q_out = r_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sc_tx_engine.sv
module sc_tx_engine
   import sc_pkg::*;
#(
   parameter int OS_RATE   = 4,
   parameter int GUARD_ETU = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              msb_first,
   input  logic              invert,
   input  logic              par_odd,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              tx_end,
   output logic              drive_low
);

   localparam int REL_SLOT = (SLOTS_PER_CHAR + GUARD_ETU > 12) ? SLOTS_PER_CHAR + GUARD_ETU : 12;
   localparam int SW       = $clog2(REL_SLOT + 1);
   localparam int PW       = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;

   localparam logic [PW-1:0] PH_LAST = PW'(OS_RATE - 1);
   localparam logic [PW-1:0] PH_MID  = PW'(OS_RATE / 2);
   localparam logic [SW-1:0] SL_END  = SW'(11);
   localparam logic [SW-1:0] SL_REL  = SW'(REL_SLOT);
   localparam logic [SW-1:0] SL_DATA = SW'(SLOTS_PER_CHAR);

   logic          busy_q;
   logic [PW-1:0] ph_q;
   logic [SW-1:0] slot_q;
   logic [15:0]   frame_q;
   logic          end_q;

   logic accept;
   logic ph_wrap;
   logic [SW-1:0] slot_inc;

   assign accept   = in_valid && !busy_q;
   assign ph_wrap  = (ph_q == PH_LAST);
   assign slot_inc = slot_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ph_q    <= '0;
         slot_q  <= '0;
         frame_q <= '1;
         end_q   <= 1'b1;
      end else if (accept) begin
         busy_q  <= 1'b1;
         ph_q    <= '0;
         slot_q  <= '0;
         frame_q <= {6'h3F, make_levels(in_data, msb_first, invert, par_odd)};
         end_q   <= 1'b0;
      end else if (busy_q && tick) begin
         if (ph_wrap) begin
            ph_q   <= '0;
            slot_q <= slot_inc;
            if (slot_inc == SL_REL) busy_q <= 1'b0;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
         if (!ph_wrap && (slot_q == SL_END) && ((ph_q + 1'b1) == PH_MID)) end_q <= 1'b1;
      end
   end

   assign in_ready  = !busy_q;
   assign tx_end    = end_q;
   assign drive_low = busy_q && (slot_q < SL_DATA) && !frame_q[slot_q[3:0]];

endmodule

// File: rtl/sc_rx_engine.sv
module sc_rx_engine
   import sc_pkg::*;
#(
   parameter int OS_RATE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line_lvl,
   input  logic              msb_first,
   input  logic              invert,
   input  logic              par_odd,
   input  logic              err_clr,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              perr,
   output logic              ovr
);

   localparam int PW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;
   localparam logic [PW-1:0] PH_LAST = PW'(OS_RATE - 1);
   localparam logic [PW-1:0] PH_MID  = PW'(OS_RATE / 2);

   typedef enum logic {RX_IDLE, RX_FRAME} rx_state_e;

   rx_state_e         st_q;
   logic [PW-1:0]     ph_q;
   logic [3:0]        idx_q;
   logic              last_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] data_q;
   logic              full_q;
   logic              perr_q;
   logic              ovr_q;

   logic start_det, at_mid, abort_c, take_c, finish_c, consume, bad_c, bit_c;
   logic [DATA_W-1:0] sh_nx;

   assign start_det = (st_q == RX_IDLE) && tick && last_q && !line_lvl;
   assign at_mid    = (st_q == RX_FRAME) && tick && ((ph_q + 1'b1) == PH_MID);
   assign abort_c   = at_mid && (idx_q == 4'd0) && line_lvl;
   assign take_c    = at_mid && (idx_q >= 4'd1) && (idx_q <= 4'd8);
   assign finish_c  = at_mid && (idx_q == 4'd9);
   assign bit_c     = line_lvl ^ invert;
   assign sh_nx     = msb_first ? {sh_q[DATA_W-2:0], bit_c} : {bit_c, sh_q[DATA_W-1:1]};
   assign bad_c     = parity_fail(sh_q, line_lvl, par_odd);
   assign consume   = full_q && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= RX_IDLE;
         ph_q   <= '0;
         idx_q  <= '0;
         last_q <= 1'b1;
         sh_q   <= '0;
         data_q <= '0;
         full_q <= 1'b0;
         perr_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (tick) last_q <= line_lvl;

         if (start_det) begin
            st_q  <= RX_FRAME;
            ph_q  <= '0;
            idx_q <= '0;
         end else if ((st_q == RX_FRAME) && tick) begin
            if (ph_q == PH_LAST) begin
               ph_q  <= '0;
               idx_q <= idx_q + 1'b1;
            end else begin
               ph_q <= ph_q + 1'b1;
            end
            if (abort_c || finish_c) st_q <= RX_IDLE;
         end

         if (take_c) sh_q <= sh_nx;

         if (finish_c) begin
            if (full_q && !consume) begin
               ovr_q <= 1'b1;
            end else begin
               data_q <= sh_q;
               full_q <= 1'b1;
            end
         end else if (consume) begin
            full_q <= 1'b0;
         end

         if (finish_c && bad_c) perr_q <= 1'b1;
         else if (err_clr)      perr_q <= 1'b0;

         if (finish_c && full_q && !consume) ovr_q <= 1'b1;
         else if (err_clr)                    ovr_q <= 1'b0;
      end
   end

   assign out_valid = full_q;
   assign out_data  = data_q;
   assign perr      = perr_q;
   assign ovr       = ovr_q;

endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
   import sc_pkg::*;
#(
   parameter int OS_RATE     = 4,
   parameter int GUARD_ETU   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       cfg_msb_first,
   input  logic       cfg_invert,
   input  logic       cfg_par_odd,
   input  logic       tx_valid,
   input  logic [7:0] tx_data,
   output logic       tx_ready,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   input  logic       rx_ready,
   input  logic       err_clr,
   output logic       stat_parity_err,
   output logic       stat_overrun,
   output logic       stat_tx_end,
   output logic       stat_err_sig,
   input  logic       line_in,
   output logic       line_drive_low
);

   generate
      if (OS_RATE < 2 || (OS_RATE % 2) != 0) begin : g_bad_os
         $error("OS_RATE must be even and at least 2");
      end
      if (GUARD_ETU < 1) begin : g_bad_guard
         $error("GUARD_ETU must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
   endgenerate

   logic line_s;

   sc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (line_in),
      .q_out (line_s)
   );

   sc_tx_engine #(.OS_RATE(OS_RATE), .GUARD_ETU(GUARD_ETU)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .msb_first (cfg_msb_first),
      .invert    (cfg_invert),
      .par_odd   (cfg_par_odd),
      .in_valid  (tx_valid),
      .in_data   (tx_data),
      .in_ready  (tx_ready),
      .tx_end    (stat_tx_end),
      .drive_low (line_drive_low)
   );

   sc_rx_engine #(.OS_RATE(OS_RATE)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (os_tick),
      .line_lvl  (line_s),
      .msb_first (cfg_msb_first),
      .invert    (cfg_invert),
      .par_odd   (cfg_par_odd),
      .err_clr   (err_clr),
      .out_ready (rx_ready),
      .out_valid (rx_valid),
      .out_data  (rx_data),
      .perr      (stat_parity_err),
      .ovr       (stat_overrun)
   );

   // Block transfer mode: no error signal is ever exchanged
   assign stat_err_sig = 1'b0;

endmodule

// File: rtl/sc_char_chk.sv
module sc_char_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       stat_tx_end,
   input logic       line_drive_low,
   input logic       rx_valid,
   input logic       rx_ready,
   input logic [7:0] rx_data,
   input logic       stat_parity_err,
   input logic       stat_overrun,
   input logic       err_clr
);

   // R4
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> !line_drive_low);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (line_drive_low && !tx_ready));

   // R5
   tx_end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !stat_tx_end);

   // R9
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

   // R7
   perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_parity_err && !err_clr) |=> stat_parity_err);

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_overrun && !err_clr) |=> stat_overrun);

endmodule

bind sc_char_xcvr sc_char_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .tx_valid        (tx_valid),
   .tx_ready        (tx_ready),
   .stat_tx_end     (stat_tx_end),
   .line_drive_low  (line_drive_low),
   .rx_valid        (rx_valid),
   .rx_ready        (rx_ready),
   .rx_data         (rx_data),
   .stat_parity_err (stat_parity_err),
   .stat_overrun    (stat_overrun),
   .err_clr         (err_clr)
);

// File: tb/sc_char_xcvr_bench.sv
`timescale 1ns/1ps
module sc_char_xcvr_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b0;
   logic       cfg_msb_first = 1'b0;
   logic       cfg_invert = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_ready;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_ready = 1'b0;
   logic       err_clr = 1'b0;
   logic       stat_parity_err, stat_overrun, stat_tx_end, stat_err_sig;
   logic       line_in;
   logic       line_drive_low;
   logic       bench_low = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   int div    = 0;

   assign line_in = !(line_drive_low || bench_low);

   sc_char_xcvr u_sc_char_xcvr (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
      .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_par_odd(cfg_par_odd),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .err_clr(err_clr), .stat_parity_err(stat_parity_err), .stat_overrun(stat_overrun),
      .stat_tx_end(stat_tx_end), .stat_err_sig(stat_err_sig),
      .line_in(line_in), .line_drive_low(line_drive_low)
   );

   always #2 clk = ~clk;

   // one strobe every 4 clocks: 4 strobes per etu
   always @(negedge clk) begin
      div     = (div == 3) ? 0 : div + 1;
      os_tick = (div == 3);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         while (!os_tick) @(posedge clk);
      end
      #1;
   endtask

   // expected line level of slot k (1 = high/released)
   function automatic logic exp_lvl(input logic [7:0] d, input int k,
                                    input logic msb, input logic inv, input logic po);
      if (k == 0) return 1'b0;
      if (k == 9) return (^d) ^ po;
      if (k > 9)  return 1'b1;
      return (msb ? d[8-k] : d[k-1]) ^ inv;
   endfunction

   task automatic set_cfg(input logic msb, input logic inv, input logic po);
      @(negedge clk);
      cfg_msb_first = msb;
      cfg_invert    = inv;
      cfg_par_odd   = po;
   endtask

   task automatic consume_rx;
      @(negedge clk) rx_ready = 1'b1;
      @(negedge clk) rx_ready = 1'b0;
      chk("R9 rx_valid drops after read", rx_valid, 1'b0);
   endtask

   task automatic pulse_clr;
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
   endtask

   // transmit one byte, check every slot, flags and loopback result
   task automatic send_tx(input logic [7:0] d);
      string tag;
      tag = (cfg_msb_first || cfg_invert) ? "R3" : "R2";
      @(negedge clk);
      tx_data  = d;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      #1 tx_valid = 1'b0;
      wait_ticks(2);
      for (int k = 0; k < 12; k++) begin
         if (k > 0) wait_ticks(4);
         if (k < 10) chk(tag, line_drive_low, !exp_lvl(d, k, cfg_msb_first, cfg_invert, cfg_par_odd));
         else        chk("R4 guard released", line_drive_low, 1'b0);
         if (k == 0)  chk("R4 busy", tx_ready, 1'b0);
         if (k == 10) chk("R5 tx_end before 11.5 etu", stat_tx_end, 1'b0);
      end
      chk("R5 tx_end at 11.5 etu", stat_tx_end, 1'b1);
      wait_ticks(1);
      chk("R4 ready held", tx_ready, 1'b0);
      wait_ticks(1);
      chk("R4 ready at 12 etu", tx_ready, 1'b1);
      chk("R6 loopback valid", rx_valid, 1'b1);
      chk("R6 loopback data", rx_data, d);
      chk("R7 no parity error", stat_parity_err, 1'b0);
      consume_rx();
   endtask

   // drive a frame from the bench side of the line
   task automatic drive_frame(input logic [7:0] d, input logic flip_par);
      logic lv;
      wait_ticks(1);
      for (int k = 0; k < 10; k++) begin
         lv = exp_lvl(d, k, cfg_msb_first, cfg_invert, cfg_par_odd);
         if (k == 9) lv = lv ^ flip_par;
         @(negedge clk) bench_low = !lv;
         wait_ticks(4);
      end
      @(negedge clk) bench_low = 1'b0;
      chk("R7 no error signal driven", line_drive_low, 1'b0);
      wait_ticks(8);
      chk("R7 line still released", line_drive_low, 1'b0);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 line", line_drive_low, 1'b0);
      chk("R1 tx_ready", tx_ready, 1'b1);
      chk("R1 tx_end", stat_tx_end, 1'b1);
      chk("R1 rx_valid", rx_valid, 1'b0);
      chk("R1 perr", stat_parity_err, 1'b0);
      chk("R1 ovr", stat_overrun, 1'b0);
      chk("R1 err_sig", stat_err_sig, 1'b0);

      // transmit sweeps over all four conventions (R2, R3, R4, R5, R6)
      for (int m = 0; m < 4; m++) begin
         set_cfg(m[1], m[0], m[0]);
         for (int b = 0; b < 256; b += ((m == 0) ? 1 : 7)) send_tx(8'(b));
      end
      set_cfg(1'b0, 1'b0, 1'b1);
      send_tx(8'hA5);
      send_tx(8'h00);

      // R6 initial characters from the bench
      set_cfg(1'b0, 1'b0, 1'b0);
      drive_frame(8'h3B, 1'b0);
      chk("R6 direct 3B valid", rx_valid, 1'b1);
      chk("R6 direct 3B", rx_data, 8'h3B);
      consume_rx();
      set_cfg(1'b1, 1'b1, 1'b1);
      drive_frame(8'h3F, 1'b0);
      chk("R6 inverse 3F", rx_data, 8'h3F);
      chk("R6 inverse no perr", stat_parity_err, 1'b0);
      consume_rx();

      // R7 / R8 parity error
      set_cfg(1'b0, 1'b0, 1'b0);
      drive_frame(8'h55, 1'b1);
      chk("R7 data delivered", rx_data, 8'h55);
      chk("R7 perr set", stat_parity_err, 1'b1);
      chk("R8 err_sig zero", stat_err_sig, 1'b0);
      consume_rx();
      drive_frame(8'h12, 1'b0);
      chk("R7 perr sticky", stat_parity_err, 1'b1);
      consume_rx();
      pulse_clr();
      chk("R7 perr cleared", stat_parity_err, 1'b0);
      set_cfg(1'b1, 1'b1, 1'b1);
      drive_frame(8'hC3, 1'b1);
      chk("R7 inverse perr", stat_parity_err, 1'b1);
      chk("R8 err_sig zero inverse", stat_err_sig, 1'b0);
      consume_rx();
      pulse_clr();

      // R9 overrun
      set_cfg(1'b0, 1'b0, 1'b0);
      drive_frame(8'h81, 1'b0);
      drive_frame(8'h7E, 1'b0);
      chk("R9 overrun set", stat_overrun, 1'b1);
      chk("R9 data kept", rx_data, 8'h81);
      chk("R9 still valid", rx_valid, 1'b1);
      pulse_clr();
      chk("R9 overrun cleared", stat_overrun, 1'b0);
      consume_rx();

      // R10 false start
      wait_ticks(1);
      @(negedge clk) bench_low = 1'b1;
      wait_ticks(1);
      @(negedge clk) bench_low = 1'b0;
      wait_ticks(48);
      chk("R10 glitch ignored", rx_valid, 1'b0);
      drive_frame(8'hE7, 1'b0);
      chk("R10 next frame valid", rx_valid, 1'b1);
      chk("R10 next frame data", rx_data, 8'hE7);
      consume_rx();

      finish_run();
   end

endmodule